// File: doc/BRIEF.md
# Isochronous Ping-Pong Endpoint Buffer

This block holds the two packet buffers of one isochronous endpoint and hands them back and forth between the local processor and the bus engine. At any moment one buffer is "active": the bus engine drains it, byte by byte, during the current frame. The other buffer is "standby": the processor fills it for the next frame. Every start-of-frame event swaps the two roles. The buffer leaving the active role is emptied at once, whether or not the bus engine finished reading it.

The start-of-frame input is an already decoded token. It carries an 11-bit frame number and a flag that says whether its CRC checked good. A token with a bad CRC still marks a frame boundary. The roles swap, the frame pulse fires and the status reports the frame as lost, but the frame-number register keeps its old value. If the bus engine never signalled a completed transfer during the frame that is ending, the status reports FULL instead of READY.

Two data-set flags tell the processor which buffer currently belongs to the bus side. They follow the swap after a fixed delay. Until they have moved, all processor writes are refused. Refused writes raise a sticky error bit that the processor clears by acknowledging it.

Top module: `iso_pingpong_buf`

## Requirements
- R1: While reset is asserted and right after it, buffer B is active (`active_b_o`=1) and A is standby, both byte counts are 0, `status_o` is READY (2'd0), `dset_a_o`=0, `dset_b_o`=1, `frame_o`=0, and `wr_err_o`=0.
- R2: On a clock edge where `sof_valid_i` is 1, the roles of A and B swap. The buffer that was active becomes standby and its count is 0 from the next cycle. The buffer that was standby keeps its bytes and count, and becomes the active one.
- R3: A start-of-frame with `sof_crc_ok_i`=1 loads `sof_frame_i` into `frame_o`, visible the cycle after. If a transfer completed in the ending frame, `status_o` becomes READY (2'd0). `xfer_done_i` counts as completed when it is seen on any edge after the previous start-of-frame, up to and including the current start-of-frame edge. Right after reset, the first frame counts as completed.
- R4: `sof_pulse_o` is 1 for exactly the one cycle that follows each start-of-frame edge.
- R5: The flag of the active buffer is 1 and the other flag is 0. After a swap, both flags keep their old values through the first two edges that follow the start-of-frame edge. They take the new roles on the third following edge.
- R6: A start-of-frame with `sof_crc_ok_i`=0 sets `status_o` to LOST (2'd2) and leaves `frame_o` unchanged. The pulse and the swap still happen. LOST takes priority over FULL.
- R7: A start-of-frame with a good CRC sets `status_o` to FULL (2'd1) when no transfer completion was seen in the ending frame.
- R8: A processor write seen on a start-of-frame edge, or on any of the next three edges, is dropped and sets `wr_err_o`. Writes are accepted again from the fourth edge on.
- R9: A write whose target (`cpu_wbuf_i`: 0 = A, 1 = B) is the active buffer is dropped and sets `wr_err_o`. A write to a standby buffer that already holds 64 bytes is also dropped and sets `wr_err_o`.
- R10: `wr_err_o` stays 1 until an edge with `err_ack_i`=1 and no dropped write. If a dropped write and the acknowledge arrive on the same edge, the bit stays set.
- R11: Accepted writes append bytes to the standby buffer in order. `bus_rdata_o` shows the oldest byte of the active buffer, and each `bus_rd_i` edge removes that byte. A read of an empty active buffer changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_valid_i | input | 1 | Decoded start-of-frame token, one cycle |
| sof_crc_ok_i | input | 1 | Token CRC checked good |
| sof_frame_i | input | 11 | Frame number carried by the token |
| xfer_done_i | input | 1 | Bus engine completed the frame's transfer |
| cpu_wr_i | input | 1 | Processor byte write strobe |
| cpu_wbuf_i | input | 1 | Write target: 0 = A, 1 = B |
| cpu_wdata_i | input | 8 | Byte to write |
| err_ack_i | input | 1 | Clears the sticky write error |
| bus_rd_i | input | 1 | Bus engine pops one byte from the active buffer |
| bus_rdata_o | output | 8 | Oldest byte of the active buffer |
| act_cnt_o | output | 7 | Bytes held by the active buffer |
| stby_cnt_o | output | 7 | Bytes held by the standby buffer |
| active_b_o | output | 1 | 1 when B is active, 0 when A is active |
| dset_a_o | output | 1 | Delayed flag: A belongs to the bus side |
| dset_b_o | output | 1 | Delayed flag: B belongs to the bus side |
| frame_o | output | 11 | Frame-number register |
| status_o | output | 2 | READY 0, FULL 1, LOST 2 |
| sof_pulse_o | output | 1 | One-cycle frame-advance pulse |
| wr_err_o | output | 1 | Sticky dropped-write error |

## Verification
A directed frame first loads buffer A and then swaps it in. This separates the immediate role change from the flag update three edges later. It also probes writes on every edge of the blocked window, so an off-by-one in the window length shows up. A start-of-frame with a bad CRC while a transfer is still pending tells the LOST-over-FULL priority apart from a plain pending frame. The same test shows that the frame register is held. A full standby buffer is swapped out to show that the outgoing buffer is discarded while the incoming one is kept. A long randomized run then mixes writes, reads, acknowledges and start-of-frame events at irregular spacing. Every cycle of that run is compared with a queue-based model.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_FULL  = 2'd1,
    ST_LOST  = 2'd2
  } iso_stat_e;

endpackage

// File: rtl/iso_pp_fifo.sv
module iso_pp_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic                         rd_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              push, pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push    = wr_i && !full_o && !clr_i;
  assign pop     = rd_i && !empty_o && !clr_i;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + AW'(1);
      if (pop)  rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)) else $error("count above depth"); // R11

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)) else $error("clear left bytes"); // R2

  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_i && !rd_i && !clr_i) |=> $stable(cnt_q)) else $error("full buffer grew"); // R9

endmodule

// File: rtl/iso_pp_ctrl.sv
module iso_pp_ctrl
  import iso_pp_pkg::*;
#(
  parameter int unsigned FRAME_W    = 11,
  parameter int unsigned DSET_DELAY = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sof_valid_i,
  input  logic               sof_crc_ok_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               xfer_done_i,
  input  logic               cpu_wr_i,
  input  logic               cpu_wbuf_i,
  input  logic               stby_full_i,
  input  logic               err_ack_i,
  output logic               active_b_o,
  output logic               clr_a_o,
  output logic               clr_b_o,
  output logic               wr_ok_o,
  output logic               dset_a_o,
  output logic               dset_b_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [1:0]         status_o,
  output logic               sof_pulse_o,
  output logic               wr_err_o
);

  localparam int unsigned HW = $clog2(DSET_DELAY+1);

  logic               active_b_q, active_b_d;
  logic [HW-1:0]      hold_q, hold_d;
  logic               dset_a_q, dset_a_d, dset_b_q, dset_b_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               frame_en;
  iso_stat_e          status_q, status_d;
  logic               pulse_q;
  logic               done_q, done_d;
  logic               werr_q, werr_d;
  logic               blocked, wr_drop, dset_en;

  // writes refused on the frame edge and for the whole flag-update delay
  assign blocked = sof_valid_i || (hold_q != '0);
  assign wr_drop = cpu_wr_i && (blocked || (cpu_wbuf_i == active_b_q) || stby_full_i);
  assign wr_ok_o = cpu_wr_i && !wr_drop;
  assign clr_a_o = sof_valid_i && !active_b_q;
  assign clr_b_o = sof_valid_i &&  active_b_q;
  assign dset_en = !sof_valid_i && (hold_q == HW'(1));
  assign frame_en = sof_valid_i && sof_crc_ok_i;

  always_comb begin
    active_b_d = sof_valid_i ? !active_b_q : active_b_q;

    if (sof_valid_i)          hold_d = HW'(DSET_DELAY);
    else if (hold_q != '0)    hold_d = hold_q - HW'(1);
    else                      hold_d = hold_q;

    dset_a_d = dset_en ? !active_b_q : dset_a_q;
    dset_b_d = dset_en ?  active_b_q : dset_b_q;

    frame_d = frame_en ? sof_frame_i : frame_q;

    status_d = status_q;
    if (sof_valid_i) begin
      if (!sof_crc_ok_i)                 status_d = ST_LOST;
      else if (!(done_q || xfer_done_i)) status_d = ST_FULL;
      else                               status_d = ST_READY;
    end

    if (sof_valid_i)      done_d = 1'b0;
    else if (xfer_done_i) done_d = 1'b1;
    else                  done_d = done_q;

    if (wr_drop)        werr_d = 1'b1;
    else if (err_ack_i) werr_d = 1'b0;
    else                werr_d = werr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_b_q <= 1'b1;
      hold_q     <= '0;
      dset_a_q   <= 1'b0;
      dset_b_q   <= 1'b1;
      frame_q    <= '0;
      status_q   <= ST_READY;
      pulse_q    <= 1'b0;
      done_q     <= 1'b1;
      werr_q     <= 1'b0;
    end else begin
      active_b_q <= active_b_d;
      hold_q     <= hold_d;
      dset_a_q   <= dset_a_d;
      dset_b_q   <= dset_b_d;
      if (frame_en) frame_q <= frame_d;
      status_q   <= status_d;
      pulse_q    <= sof_valid_i;
      done_q     <= done_d;
      werr_q     <= werr_d;
    end
  end

  assign active_b_o  = active_b_q;
  assign dset_a_o    = dset_a_q;
  assign dset_b_o    = dset_b_q;
  assign frame_o     = frame_q;
  assign status_o    = status_q;
  assign sof_pulse_o = pulse_q;
  assign wr_err_o    = werr_q;

  AST_DSET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dset_a_q != dset_b_q) else $error("data-set flags not exclusive"); // R5

  AST_DSET_HOLD_AFTER_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid_i |=> $stable({dset_a_q, dset_b_q})) else $error("flags moved early"); // R5

  AST_LOST_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_valid_i && !sof_crc_ok_i) |=> ($stable(frame_q) && status_q == ST_LOST))
    else $error("bad-CRC frame handling"); // R6

  AST_NO_WRITE_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid_i |-> !wr_ok_o) else $error("write accepted on frame edge"); // R8

endmodule

// File: rtl/iso_pingpong_buf.sv
module iso_pingpong_buf #(
  parameter int unsigned FRAME_W    = 11,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned DSET_DELAY = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sof_valid_i,
  input  logic                       sof_crc_ok_i,
  input  logic [FRAME_W-1:0]         sof_frame_i,
  input  logic                       xfer_done_i,
  input  logic                       cpu_wr_i,
  input  logic                       cpu_wbuf_i,
  input  logic [DATA_W-1:0]          cpu_wdata_i,
  input  logic                       err_ack_i,
  input  logic                       bus_rd_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] act_cnt_o,
  output logic [$clog2(DEPTH+1)-1:0] stby_cnt_o,
  output logic                       active_b_o,
  output logic                       dset_a_o,
  output logic                       dset_b_o,
  output logic [FRAME_W-1:0]         frame_o,
  output logic [1:0]                 status_o,
  output logic                       sof_pulse_o,
  output logic                       wr_err_o
);

  localparam int unsigned CW   = $clog2(DEPTH+1);
  localparam int unsigned NBUF = 2;

  logic              active_b, wr_ok, clr_a, clr_b, stby_full;
  logic              clr_v   [NBUF];
  logic              wr_v    [NBUF];
  logic              rd_v    [NBUF];
  logic              full_v  [NBUF];
  logic              empty_v [NBUF];
  logic [DATA_W-1:0] rdata_v [NBUF];
  logic [CW-1:0]     cnt_v   [NBUF];

  iso_pp_ctrl #(
    .FRAME_W    (FRAME_W),
    .DSET_DELAY (DSET_DELAY)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof_valid_i  (sof_valid_i),
    .sof_crc_ok_i (sof_crc_ok_i),
    .sof_frame_i  (sof_frame_i),
    .xfer_done_i  (xfer_done_i),
    .cpu_wr_i     (cpu_wr_i),
    .cpu_wbuf_i   (cpu_wbuf_i),
    .stby_full_i  (stby_full),
    .err_ack_i    (err_ack_i),
    .active_b_o   (active_b),
    .clr_a_o      (clr_a),
    .clr_b_o      (clr_b),
    .wr_ok_o      (wr_ok),
    .dset_a_o     (dset_a_o),
    .dset_b_o     (dset_b_o),
    .frame_o      (frame_o),
    .status_o     (status_o),
    .sof_pulse_o  (sof_pulse_o),
    .wr_err_o     (wr_err_o)
  );

  assign clr_v[0] = clr_a;
  assign clr_v[1] = clr_b;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    assign wr_v[g] = wr_ok    && (cpu_wbuf_i == 1'(g));
    assign rd_v[g] = bus_rd_i && (active_b   == 1'(g));

    iso_pp_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_v[g]),
      .wr_i    (wr_v[g]),
      .wdata_i (cpu_wdata_i),
      .rd_i    (rd_v[g]),
      .rdata_o (rdata_v[g]),
      .count_o (cnt_v[g]),
      .full_o  (full_v[g]),
      .empty_o (empty_v[g])
    );
  end

  assign stby_full   = full_v[~active_b];
  assign bus_rdata_o = rdata_v[active_b];
  assign act_cnt_o   = cnt_v[active_b];
  assign stby_cnt_o  = cnt_v[~active_b];
  assign active_b_o  = active_b;

  AST_NEW_STANDBY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    sof_valid_i |=> (stby_cnt_o == '0)) else $error("outgoing buffer kept data"); // R2

  AST_STANDBY_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof_valid_i && !(wr_ok)) |=> (stby_cnt_o == $past(stby_cnt_o)))
    else $error("standby count moved without a write"); // R11

endmodule

// File: tb/iso_pingpong_buf_bench.sv
`timescale 1ns/1ps
module iso_pingpong_buf_bench;

  localparam int FW = 11;
  localparam int DEPTH = 64;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic sof_v, crc_ok, xfer_done, cpu_wr, cpu_wbuf, err_ack, bus_rd;
  logic [FW-1:0] sof_frame;
  logic [7:0] cpu_wdata, bus_rdata;
  logic [6:0] act_cnt, stby_cnt;
  logic active_b, dset_a, dset_b, sof_pulse, wr_err;
  logic [FW-1:0] frame;
  logic [1:0] status;

  always #10 clk = ~clk;

  iso_pingpong_buf u_iso_pingpong_buf (
    .clk(clk), .rst_n(rst_n), .sof_valid_i(sof_v), .sof_crc_ok_i(crc_ok),
    .sof_frame_i(sof_frame), .xfer_done_i(xfer_done), .cpu_wr_i(cpu_wr),
    .cpu_wbuf_i(cpu_wbuf), .cpu_wdata_i(cpu_wdata), .err_ack_i(err_ack),
    .bus_rd_i(bus_rd), .bus_rdata_o(bus_rdata), .act_cnt_o(act_cnt),
    .stby_cnt_o(stby_cnt), .active_b_o(active_b), .dset_a_o(dset_a),
    .dset_b_o(dset_b), .frame_o(frame), .status_o(status),
    .sof_pulse_o(sof_pulse), .wr_err_o(wr_err)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit run_cmp = 0;

  // behavioural reference
  byte unsigned qa[$], qb[$];
  bit m_act_b, m_da, m_db, m_pulse, m_done, m_werr, m_blk, m_drop;
  int m_hold, m_frame, m_stat, m_ssz;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa.delete(); qb.delete();
      m_act_b = 1; m_hold = 0; m_da = 0; m_db = 1; m_frame = 0;
      m_stat = 0; m_pulse = 0; m_done = 1; m_werr = 0;
    end else begin
      m_ssz  = m_act_b ? qa.size() : qb.size();
      m_blk  = sof_v || (m_hold != 0);
      m_drop = cpu_wr && (m_blk || (cpu_wbuf == m_act_b) || m_ssz == DEPTH);
      if (bus_rd && !sof_v) begin
        if (m_act_b) begin if (qb.size() > 0) void'(qb.pop_front()); end
        else         begin if (qa.size() > 0) void'(qa.pop_front()); end
      end
      if (cpu_wr && !m_drop) begin
        if (cpu_wbuf) qb.push_back(cpu_wdata); else qa.push_back(cpu_wdata);
      end
      if (sof_v) begin
        if (m_act_b) qb.delete(); else qa.delete();
        if (!crc_ok) m_stat = 2;
        else if (!(m_done || xfer_done)) m_stat = 1;
        else m_stat = 0;
        if (crc_ok) m_frame = sof_frame;
        m_act_b = !m_act_b; m_hold = DLY; m_done = 0;
      end else begin
        if (m_hold == 1) begin m_da = !m_act_b; m_db = m_act_b; end
        if (m_hold > 0) m_hold--;
        if (xfer_done) m_done = 1;
      end
      m_pulse = sof_v;
      if (m_drop) m_werr = 1; else if (err_ack) m_werr = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R2 active_b", active_b, m_act_b);
      chk("R2 act_cnt", act_cnt, m_act_b ? qb.size() : qa.size());
      chk("R2 stby_cnt", stby_cnt, m_act_b ? qa.size() : qb.size());
      chk("R5 dset_a", dset_a, m_da);
      chk("R5 dset_b", dset_b, m_db);
      chk("R3 frame", frame, m_frame);
      chk("R7 status", status, m_stat);
      chk("R4 sof_pulse", sof_pulse, m_pulse);
      chk("R10 wr_err", wr_err, m_werr);
      if (m_act_b && qb.size() > 0) chk("R11 rdata", bus_rdata, qb[0]);
      if (!m_act_b && qa.size() > 0) chk("R11 rdata", bus_rdata, qa[0]);
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic tick();
    @(negedge clk);
    sof_v = 0; xfer_done = 0; cpu_wr = 0; err_ack = 0; bus_rd = 0;
  endtask

  task automatic do_sof(input bit ok, input int fr, input bit dn);
    sof_v = 1; crc_ok = ok; sof_frame = FW'(fr); xfer_done = dn;
    tick();
  endtask

  task automatic do_wr(input bit b, input int d);
    cpu_wr = 1; cpu_wbuf = b; cpu_wdata = 8'(d);
    tick();
  endtask

  initial begin
    rst_n = 0; sof_v = 0; crc_ok = 1; sof_frame = '0; xfer_done = 0;
    cpu_wr = 0; cpu_wbuf = 0; cpu_wdata = '0; err_ack = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    chk("R1 active_b", active_b, 1);
    chk("R1 dset_a", dset_a, 0);
    chk("R1 dset_b", dset_b, 1);
    chk("R1 status", status, 0);
    chk("R1 counts", act_cnt + stby_cnt, 0);
    chk("R1 frame", frame, 0);
    chk("R1 wr_err", wr_err, 0);
    rst_n = 1; run_cmp = 1;
    tick();

    for (int i = 0; i < 5; i++) do_wr(0, 8'h10 + i);
    chk("R11 standby fill", stby_cnt, 5);

    do_sof(1, 11'h7A5, 0);
    chk("R4 pulse high", sof_pulse, 1);
    chk("R2 swapped", active_b, 0);
    chk("R2 incoming kept", act_cnt, 5);
    chk("R3 frame load", frame, 11'h7A5);
    chk("R3 ready", status, 0);
    chk("R5 no change at edge", dset_b, 1);
    do_wr(1, 8'hEE);
    chk("R4 pulse single", sof_pulse, 0);
    chk("R8 blocked edge1", stby_cnt, 0);
    chk("R8 error set", wr_err, 1);
    tick();
    chk("R5 old after edge2", dset_a, 0);
    do_wr(1, 8'hEF);
    chk("R8 blocked edge3", stby_cnt, 0);
    chk("R5 new after edge3 a", dset_a, 1);
    chk("R5 new after edge3 b", dset_b, 0);
    do_wr(1, 8'h77);
    chk("R8 accepted edge4", stby_cnt, 1);
    err_ack = 1; tick();
    chk("R10 ack clears", wr_err, 0);

    for (int i = 0; i < 5; i++) begin
      chk("R11 read order", bus_rdata, 8'h10 + i);
      bus_rd = 1; tick();
    end
    bus_rd = 1; tick();
    chk("R11 empty read", act_cnt, 0);

    do_wr(0, 8'h55);
    chk("R9 active write dropped", act_cnt, 0);
    chk("R9 error", wr_err, 1);
    cpu_wr = 1; cpu_wbuf = 0; cpu_wdata = 8'h56; err_ack = 1; tick();
    chk("R10 drop beats ack", wr_err, 1);
    err_ack = 1; tick();
    chk("R10 cleared", wr_err, 0);

    for (int i = 1; i < DEPTH; i++) do_wr(1, i);
    chk("R9 full", stby_cnt, DEPTH);
    do_wr(1, 8'hAA);
    chk("R9 overflow dropped", stby_cnt, DEPTH);
    chk("R9 overflow error", wr_err, 1);

    do_sof(0, 11'h123, 0);
    chk("R6 lost", status, 2);
    chk("R6 frame kept", frame, 11'h7A5);
    chk("R6 pulse", sof_pulse, 1);
    chk("R6 swap", active_b, 1);
    chk("R6 incoming kept", act_cnt, DEPTH);
    repeat (4) tick();

    do_sof(1, 11'h124, 0);
    chk("R7 full", status, 1);
    chk("R2 outgoing discarded", stby_cnt, 0);
    chk("R7 frame", frame, 11'h124);
    repeat (4) tick();
    do_sof(1, 11'h125, 1);
    chk("R3 done same edge ready", status, 0);

    for (int n = 0; n < 6000; n++) begin
      sof_v     = ($urandom_range(0, 39) == 0);
      crc_ok    = ($urandom_range(0, 9) != 0);
      sof_frame = FW'($urandom);
      xfer_done = ($urandom_range(0, 24) == 0);
      cpu_wr    = ($urandom_range(0, 1) == 1);
      cpu_wbuf  = 1'($urandom);
      cpu_wdata = 8'($urandom);
      bus_rd    = ($urandom_range(0, 2) == 0);
      err_ack   = ($urandom_range(0, 15) == 0);
      tick();
    end
    repeat (2) tick();
    report();
  end

endmodule